// File: doc/BRIEF.md
# Background tile prefetch pixel pipeline

This block is the background half of a tile-based video generator. While a scanline is drawn it keeps pattern bits for the tile on screen and the tile after it in shift registers. New tile data is taken from a fetch port two tiles before it is shown. Because the data is already in the registers, the pixel for horizontal position N comes out combinationally in dot cycle N, with no pipeline offset.

A fine horizontal scroll value picks which register bit is shown, so the pixel belongs to column N plus the scroll. The two attribute bits of each tile travel with its pattern bits and together form a 4-bit palette index. A greyscale bit masks that index in the cycle it is driven.

The block also compares each background pixel with the sprite-zero pixel that the sprite logic supplies for the same dot. On a collision it raises a sticky hit flag in that same cycle. A frame-start pulse clears the flag.

The line has `LINE_DOTS` dots. Dots 0 to `VIS-1` are visible. The last 16 dots of the line form the prefetch window, which loads the first two tiles of the next line.

Top module: `bgShiftPipe`

## Requirements
- R1: While `dotX < VIS`, `pixIdx` shows, in that same cycle, the pixel for column `dotX + fineX` of the current line, taken from the already latched tiles (tile = column/8, bit 7 - column%8 of each byte, MSB leftmost). `pixValid` is 1 in that cycle.
- R2: Fetch-port data is sampled only at the clock edge that ends a load dot, and ignored in every other cycle. The visible load dots are those with `dotX % 8 == 7`; the one at dot 8k+7 supplies tile k+2. The prefetch window covers dots `LINE_DOTS-16` to `LINE_DOTS-1`; its 8th dot supplies tile 0 of the next line and its 16th dot supplies tile 1.
- R3: Whatever the fetch port shows from dot 0 onward has no effect on the pixels of dots 0 to 15 when `fineX` is 0. With a non-zero `fineX` the affected dots end earlier, at 15 minus `fineX`.
- R4: The hit flag `spr0Hit` goes to 1 in the same cycle as a visible dot in which the background pattern bits {hi,lo} are non-zero and `spr0Opaque` is 1. It stays at 1 until it is cleared.
- R5: No collision is detected at dot `VIS-1` (column 255 by default).
- R6: In a cycle with `frameStart` high, `spr0Hit` shows only a collision from that cycle. From the next cycle the stored flag is cleared.
- R7: When `greyMode` is 1, `pixIdx` is the index ANDed with `GREY_MASK` (default 4'b1100) in that same cycle. Collision detection uses the unmasked pattern bits.
- R8: `fineX` (0 to 7) selects the column offset, so a pixel may come from the following tile.
- R9: The palette index is {attr[1], attr[0], hi, lo}, where `patHi` supplies hi, `patLo` supplies lo and `attrBits` is the tile's 2-bit attribute.
- R10: Outside the visible dots, `pixValid` and `pixIdx` are 0.
- R11: During reset, `pixIdx`, `pixValid` and `spr0Hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | dot clock |
| rst_n | input | 1 | active-low synchronous reset |
| frameStart | input | 1 | clears the stored hit flag |
| dotX | input | DOT_W | dot counter within the line |
| patLo | input | 8 | low bitplane byte from the fetch port |
| patHi | input | 8 | high bitplane byte from the fetch port |
| attrBits | input | 2 | tile attribute from the fetch port |
| fineX | input | 3 | fine horizontal scroll |
| spr0Opaque | input | 1 | sprite-zero pixel non-transparent at this dot |
| greyMode | input | 1 | greyscale enable |
| pixIdx | output | 4 | palette index of the current pixel |
| pixValid | output | 1 | current dot is visible |
| spr0Hit | output | 1 | sprite-zero collision flag |

## Verification
The cycle-exact output of a pixel and the cycle-exact setting of the hit flag land on the same dot. A mid-line change of the greyscale bit can also fall in that dot. The bench opens a sprite-zero window at a random place on each line, drives `spr0Opaque` at column 255 as well, and toggles greyscale at random. In every cycle it compares `pixIdx` and `spr0Hit` with a model built from the tile bytes it recorded at the load dots. A flag or pixel that is late by one dot, or that is masked before the collision test, shows up as a mismatch in that exact dot.

// File: rtl/bgPipePkg.sv
package bgPipePkg;
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic visible;
    logic lastCol;
  } pipeStrobe_t;
endpackage

// File: rtl/bgPipeCtrl.sv
module bgPipeCtrl
  import bgPipePkg::*;
#(
  parameter int VIS       = 256,
  parameter int LINE_DOTS = 341,
  parameter int DOT_W     = 9
) (
  input  logic [DOT_W-1:0] dotX,
  output pipeStrobe_t      strb
);
  localparam int PRE_START = LINE_DOTS - 16;

  logic       inVis;
  logic       inPre;
  logic [2:0] preOff;

  // phase of the dot inside the prefetch window, modulo one tile
  assign preOff = dotX[2:0] - 3'(PRE_START % 8);
  assign inVis  = dotX < DOT_W'(VIS);
  assign inPre  = (dotX >= DOT_W'(PRE_START)) && (dotX < DOT_W'(LINE_DOTS));

  always_comb begin
    strb.visible = inVis;
    strb.shiftEn = inVis | inPre;
    strb.loadEn  = (inVis && dotX[2:0] == 3'd7) || (inPre && preOff == 3'd7);
    strb.lastCol = dotX == DOT_W'(VIS - 1);
  end
endmodule

// File: rtl/bgPipeData.sv
module bgPipeData
  import bgPipePkg::*;
#(
  parameter logic [3:0] GREY_MASK = 4'b1100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  pipeStrobe_t strb,
  input  logic        frameStart,
  input  logic [7:0]  patLo,
  input  logic [7:0]  patHi,
  input  logic [1:0]  attrBits,
  input  logic [2:0]  fineX,
  input  logic        spr0Opaque,
  input  logic        greyMode,
  output logic [3:0]  pixIdx,
  output logic        pixValid,
  output logic        spr0Hit
);
  localparam int PLANES = 4;
  localparam int SR_W   = 16;

  logic [7:0]      planeIn [PLANES];
  logic [SR_W-1:0] planeSr [PLANES];
  logic [3:0]      rawIdx;
  logic [3:0]      sel;
  logic            bgOpaque;
  logic            hitNow;
  logic            hitSticky;

  assign planeIn[0] = patLo;
  assign planeIn[1] = patHi;
  assign planeIn[2] = {8{attrBits[0]}};
  assign planeIn[3] = {8{attrBits[1]}};
  assign sel        = 4'd15 - {1'b0, fineX};

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    always_ff @(posedge clk) begin
      if (!rst_n)
        planeSr[p] <= '0;
      else if (strb.loadEn)
        planeSr[p] <= {planeSr[p][SR_W-2:7], planeIn[p]};
      else if (strb.shiftEn)
        planeSr[p] <= {planeSr[p][SR_W-2:0], 1'b0};
    end
    assign rawIdx[p] = planeSr[p][sel];
  end

  assign bgOpaque = rawIdx[1:0] != 2'b00;
  assign hitNow   = strb.visible && !strb.lastCol && bgOpaque && spr0Opaque;
  assign pixValid = rst_n && strb.visible;
  assign pixIdx   = pixValid ? (rawIdx & (greyMode ? GREY_MASK : 4'hF)) : 4'h0;
  assign spr0Hit  = rst_n && ((hitSticky && !frameStart) || hitNow);

  always_ff @(posedge clk) begin
    if (!rst_n)
      hitSticky <= 1'b0;
    else if (frameStart)
      hitSticky <= hitNow;
    else if (hitNow)
      hitSticky <= 1'b1;
  end

  assert_load_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadEn |-> strb.shiftEn);
  assert_hit_rise_opaque_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spr0Hit) |-> (spr0Opaque && pixValid));
  assert_hit_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spr0Hit && !frameStart) |=> spr0Hit || frameStart);
  assert_no_last_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.lastCol && !hitSticky) |-> !spr0Hit);
  assert_frame_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStart && !spr0Opaque) |=> !hitSticky);
  assert_grey_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    greyMode |-> ((pixIdx & ~GREY_MASK) == 4'h0));
  assert_blank_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pixValid |-> (pixIdx == 4'h0));
endmodule

// File: rtl/bgShiftPipe.sv
module bgShiftPipe
  import bgPipePkg::*;
#(
  parameter int         VIS       = 256,
  parameter int         LINE_DOTS = 341,
  parameter int         DOT_W     = 9,
  parameter logic [3:0] GREY_MASK = 4'b1100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frameStart,
  input  logic [DOT_W-1:0] dotX,
  input  logic [7:0]       patLo,
  input  logic [7:0]       patHi,
  input  logic [1:0]       attrBits,
  input  logic [2:0]       fineX,
  input  logic             spr0Opaque,
  input  logic             greyMode,
  output logic [3:0]       pixIdx,
  output logic             pixValid,
  output logic             spr0Hit
);
  pipeStrobe_t strb;

  initial begin
    assert (VIS % 8 == 0 && LINE_DOTS >= VIS + 16 && LINE_DOTS <= (1 << DOT_W))
      else $error("bgShiftPipe: bad line geometry");
  end

  bgPipeCtrl #(.VIS(VIS), .LINE_DOTS(LINE_DOTS), .DOT_W(DOT_W)) u_ctrl (
    .dotX (dotX),
    .strb (strb)
  );

  bgPipeData #(.GREY_MASK(GREY_MASK)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .frameStart (frameStart),
    .patLo      (patLo),
    .patHi      (patHi),
    .attrBits   (attrBits),
    .fineX      (fineX),
    .spr0Opaque (spr0Opaque),
    .greyMode   (greyMode),
    .pixIdx     (pixIdx),
    .pixValid   (pixValid),
    .spr0Hit    (spr0Hit)
  );
endmodule

// File: tb/bgShiftPipe_test.sv
module bgShiftPipe_test;
  localparam int CLK_PERIOD = 10;
  localparam int VIS        = 256;
  localparam int LINE_DOTS  = 341;
  localparam int PRE        = LINE_DOTS - 16;
  localparam logic [3:0] GMASK = 4'b1100;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       frameStart = 0;
  logic [8:0] dotX = 0;
  logic [7:0] patLo = 0, patHi = 0;
  logic [1:0] attrBits = 0;
  logic [2:0] fineX = 0;
  logic       spr0Opaque = 0, greyMode = 0;
  logic [3:0] pixIdx;
  logic       pixValid, spr0Hit;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] tLo [34];
  logic [7:0] tHi [34];
  logic [1:0] tAt [34];
  bit expSticky = 0;

  bgShiftPipe uut (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .dotX(dotX),
    .patLo(patLo), .patHi(patHi), .attrBits(attrBits), .fineX(fineX),
    .spr0Opaque(spr0Opaque), .greyMode(greyMode),
    .pixIdx(pixIdx), .pixValid(pixValid), .spr0Hit(spr0Hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s dot %0d: actual %0d expected %0d", tag, dotX, act, exp);
    end
  endtask

  // one dot: drive at negedge, compare, then advance the model with the edge
  task automatic dot(input int x, input int sprLo, input int sprHi, input bit spr255);
    int col, tl, b;
    logic [3:0] raw, expPix;
    bit bgOp, hitNow, expHit;
    @(negedge clk);
    dotX = 9'(x);
    patLo = 8'($urandom); patHi = 8'($urandom); attrBits = 2'($urandom);
    if (($urandom % 8) == 0) greyMode = ~greyMode;      // mid-line greyscale, R7
    if (x == 100) fineX = 3'($urandom);                // mid-line fine scroll, R8
    spr0Opaque = (x >= sprLo && x < sprHi) || (spr255 && x == VIS - 1);
    frameStart = (x == 300);
    #1;
    if (x < VIS) begin
      col = x + fineX; tl = col / 8; b = 7 - (col % 8);
      raw = {tAt[tl][1], tAt[tl][0], tHi[tl][b], tLo[tl][b]};   // R9 order
      expPix = greyMode ? (raw & GMASK) : raw;
      bgOp = raw[1:0] != 0;
      hitNow = bgOp && spr0Opaque && (x != VIS - 1);
      if (x < 16) check("R2/R3 pixel", pixIdx, expPix);
      else if (greyMode) check("R7 pixel", pixIdx, expPix);
      else check("R1/R8/R9 pixel", pixIdx, expPix);
      check("R1 valid", pixValid, 1);
    end else begin
      hitNow = 0;
      check("R10 pixel", pixIdx, 0);
      check("R10 valid", pixValid, 0);
    end
    expHit = (expSticky && !frameStart) || hitNow;
    if (x == VIS - 1) check("R5 hit", spr0Hit, expHit);
    else if (frameStart) check("R6 hit", spr0Hit, expHit);
    else check("R4 hit", spr0Hit, expHit);
    expSticky = frameStart ? hitNow : (expSticky | hitNow);
    // record fetch data latched at this edge (R2)
    if (x < VIS && (x % 8) == 7 && (x / 8 + 2) < 34) begin
      tLo[x/8+2] = patLo; tHi[x/8+2] = patHi; tAt[x/8+2] = attrBits;
    end else if (x == PRE + 7) begin
      tLo[0] = patLo; tHi[0] = patHi; tAt[0] = attrBits;
    end else if (x == PRE + 15) begin
      tLo[1] = patLo; tHi[1] = patHi; tAt[1] = attrBits;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 34; i++) begin tLo[i] = 0; tHi[i] = 0; tAt[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset pixel", pixIdx, 0);
    check("R11 reset valid", pixValid, 0);
    check("R11 reset hit", spr0Hit, 0);
    @(negedge clk);
    rst_n = 1;
    // prefetch window of the line before line 0
    for (int x = PRE; x < LINE_DOTS; x++) dot(x, 0, 0, 0);
    for (int ln = 0; ln < 8; ln++) begin
      int lo;
      lo = int'($urandom % 240);
      fineX = (ln == 0) ? 3'd0 : 3'($urandom);
      for (int x = 0; x < LINE_DOTS; x++) begin
        if (ln == 1) dot(x, 0, 0, 1);               // only column 255, R5
        else if (ln == 2) dot(x, 0, 16, 0);          // collision at the first tiles
        else dot(x, lo, lo + 6, ln % 2 == 0);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule